// File: doc/BRIEF.md
# ALU Flag Generator and Condition Evaluator

This block is the 8-bit arithmetic and logic slice of a small processor core. Each enabled cycle it takes an operation code, a destination operand, a source operand and the present flag byte. It then registers the 8-bit result together with the updated flag byte. The update rules depend on the class of the operation: add, subtract, logical, or rotate/shift. Carry, zero, sign, overflow, decimal-direction and half-carry flags are each written, cleared or left alone according to those rules. Two general-purpose user flags always pass through unchanged.

A separate combinational evaluator decodes a 4-bit condition code against the present flag byte. It raises `cond_true` when a conditional jump would be taken. The sequencer feeds the registered flags back as `flags_in` for the next operation, so carry-in for the with-carry forms is taken from `flags_in`.

The flag byte layout is: bit 7 carry (C), bit 6 zero (Z), bit 5 sign (S), bit 4 overflow (V), bit 3 decimal direction (D), bit 2 half carry (H), bit 1 user flag 2, bit 0 user flag 1.

Top module: `alu_flag_unit`

## Requirements
- R1: Op 0 (add) gives A+B and op 1 (add with carry) gives A+B+flags_in[7]. C is the carry out of bit 7, H is the carry out of bit 3, and D is cleared.
- R2: Op 2 (subtract) gives A-B and op 3 (subtract with borrow) gives A-B-flags_in[7]. C is set when a borrow into bit 7 occurs, H is set when a borrow from bit 4 occurs, and D is set to 1.
- R3: For ops 0 to 12, Z (bit 6) is 1 exactly when the 8-bit result is 00h.
- R4: For ops 0 to 12, S (bit 5) equals bit 7 of the result.
- R5: V (bit 4) is set after an add when A and B have the same sign and the result's sign differs from it. V is set after a subtract when A and B differ in sign and the result's sign equals B's sign.
- R6: Ops 4, 5 and 6 (AND, OR, XOR) clear V and leave C, D and H equal to flags_in.
- R7: The rotates are op 7 (left), op 8 (left through carry), op 9 (right) and op 10 (right through carry). The shifts are op 11 (arithmetic right) and op 12 (logical right). For all six, C takes the bit moved out and V is set when bit 7 differs between operand and result. D and H are unchanged.
- R8: Bits 1 and 0 (user flags) of flags_q always equal flags_in bits 1 and 0 of the enabled cycle.
- R9: Op codes 13 to 15 register A as the result and flags_in unchanged as the flags.
- R10: With `en` low, res_q and flags_q hold their values. After reset both are 00h.
- R11: cond_true decodes cc as follows: 0 false, 1 S^V, 2 Z|(S^V), 3 C|Z, 4 V, 5 S, 6 Z, 7 C, 8 true. Codes 9 to F are the complements of codes 1 to 7 in order. The decode uses flags_in.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Operation enable; registers result and flags |
| op | input | 4 | Operation code |
| opnd_a | input | 8 | Destination operand (A) |
| opnd_b | input | 8 | Source operand (B) |
| flags_in | input | 8 | Present flag byte |
| cc | input | 4 | Condition code to evaluate |
| res_q | output | 8 | Registered result |
| flags_q | output | 8 | Registered next flag byte |
| cond_true | output | 1 | Condition holds on flags_in |

## Verification
A wrong flag rule shows up in flags_q one clock after the enabled cycle. Because the bench feeds flags_q back as flags_in, a bad carry also corrupts the next with-carry result or rotate-through-carry result one cycle later. A broken condition decode is visible on cond_true in the same cycle that cc and flags_in are applied. The bench sweeps all sixteen codes over many flag patterns. Stale or leaking register state shows as res_q or flags_q moving while en is low.

// File: rtl/alu_flag_pkg.sv
package alu_flag_pkg;
  localparam int DW   = 8;
  localparam int HALF = DW / 2;

  localparam logic [3:0] OP_ADD = 4'd0;
  localparam logic [3:0] OP_ADC = 4'd1;
  localparam logic [3:0] OP_SUB = 4'd2;
  localparam logic [3:0] OP_SBC = 4'd3;
  localparam logic [3:0] OP_AND = 4'd4;
  localparam logic [3:0] OP_OR  = 4'd5;
  localparam logic [3:0] OP_XOR = 4'd6;
  localparam logic [3:0] OP_RL  = 4'd7;
  localparam logic [3:0] OP_RLC = 4'd8;
  localparam logic [3:0] OP_RR  = 4'd9;
  localparam logic [3:0] OP_RRC = 4'd10;
  localparam logic [3:0] OP_SRA = 4'd11;
  localparam logic [3:0] OP_SRL = 4'd12;

  typedef struct packed {
    logic c;
    logic z;
    logic s;
    logic v;
    logic d;
    logic h;
    logic u2;
    logic u1;
  } flags_t;
endpackage

// File: rtl/alu_addsub.sv
module alu_addsub #(
  parameter int W    = 8,
  parameter int HALF = W / 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         cin,
  output logic [W-1:0] r,
  output logic         cout,
  output logic         hc,
  output logic         ovf
);
  logic [W:0]    full;
  logic [HALF:0] low;

  always_comb begin
    if (sub) begin
      full = {1'b0, a} - {1'b0, b} - {{W{1'b0}}, cin};
      low  = {1'b0, a[HALF-1:0]} - {1'b0, b[HALF-1:0]} - {{HALF{1'b0}}, cin};
    end else begin
      full = {1'b0, a} + {1'b0, b} + {{W{1'b0}}, cin};
      low  = {1'b0, a[HALF-1:0]} + {1'b0, b[HALF-1:0]} + {{HALF{1'b0}}, cin};
    end
    r    = full[W-1:0];
    cout = full[W];
    hc   = low[HALF];
    if (sub) ovf = (a[W-1] ^ b[W-1]) & ~(r[W-1] ^ b[W-1]);
    else     ovf = ~(a[W-1] ^ b[W-1]) & (r[W-1] ^ a[W-1]);
  end
endmodule

// File: rtl/alu_bitops.sv
module alu_bitops
  import alu_flag_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [3:0]   op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] r,
  output logic         cout
);
  always_comb begin
    r    = a;
    cout = cin;
    unique case (op)
      OP_AND: r = a & b;
      OP_OR:  r = a | b;
      OP_XOR: r = a ^ b;
      OP_RL:  begin r = {a[W-2:0], a[W-1]}; cout = a[W-1]; end
      OP_RLC: begin r = {a[W-2:0], cin};    cout = a[W-1]; end
      OP_RR:  begin r = {a[0], a[W-1:1]};   cout = a[0];   end
      OP_RRC: begin r = {cin, a[W-1:1]};    cout = a[0];   end
      OP_SRA: begin r = {a[W-1], a[W-1:1]}; cout = a[0];   end
      OP_SRL: begin r = {1'b0, a[W-1:1]};   cout = a[0];   end
      default: begin r = a; cout = cin; end
    endcase
  end
endmodule

// File: rtl/alu_cond.sv
module alu_cond
  import alu_flag_pkg::*;
(
  input  flags_t     f,
  input  logic [3:0] cc,
  output logic       taken
);
  logic base;
  logic lt;

  always_comb begin
    lt = f.s ^ f.v;
    unique case (cc[2:0])
      3'd0: base = 1'b0;
      3'd1: base = lt;
      3'd2: base = f.z | lt;
      3'd3: base = f.c | f.z;
      3'd4: base = f.v;
      3'd5: base = f.s;
      3'd6: base = f.z;
      default: base = f.c;
    endcase
    taken = base ^ cc[3];
  end
endmodule

// File: rtl/alu_flag_unit.sv
module alu_flag_unit
  import alu_flag_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [3:0]    op,
  input  logic [DW-1:0] opnd_a,
  input  logic [DW-1:0] opnd_b,
  input  logic [7:0]    flags_in,
  input  logic [3:0]    cc,
  output logic [DW-1:0] res_q,
  output logic [7:0]    flags_q,
  output logic          cond_true
);
  flags_t        fin;
  flags_t        fnxt;
  flags_t        freg;
  logic [DW-1:0] res_nxt;
  logic [DW-1:0] as_r, bo_r;
  logic          as_c, as_h, as_v, bo_c;
  logic          is_arith, is_sub, is_logic, is_shift;

  assign fin      = flags_t'(flags_in);
  assign is_arith = (op <= OP_SBC);
  assign is_sub   = (op == OP_SUB) || (op == OP_SBC);
  assign is_logic = (op >= OP_AND) && (op <= OP_XOR);
  assign is_shift = (op >= OP_RL) && (op <= OP_SRL);

  alu_addsub #(.W(DW), .HALF(HALF)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sub(is_sub), .cin(op[0] & fin.c),
    .r(as_r), .cout(as_c), .hc(as_h), .ovf(as_v)
  );

  alu_bitops #(.W(DW)) u_bitops (
    .op(op), .a(opnd_a), .b(opnd_b), .cin(fin.c), .r(bo_r), .cout(bo_c)
  );

  alu_cond u_cond (.f(fin), .cc(cc), .taken(cond_true));

  always_comb begin
    fnxt    = fin;
    res_nxt = opnd_a;
    if (is_arith) begin
      res_nxt = as_r;
      fnxt.c  = as_c;
      fnxt.h  = as_h;
      fnxt.v  = as_v;
      fnxt.d  = is_sub;
    end else if (is_logic) begin
      res_nxt = bo_r;
      fnxt.v  = 1'b0;
    end else if (is_shift) begin
      res_nxt = bo_r;
      fnxt.c  = bo_c;
      fnxt.v  = bo_r[DW-1] ^ opnd_a[DW-1];
    end
    if (is_arith || is_logic || is_shift) begin
      fnxt.z = (res_nxt == '0);
      fnxt.s = res_nxt[DW-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
      freg  <= '0;
    end else if (en) begin
      res_q <= res_nxt;
      freg  <= fnxt;
    end
  end

  assign flags_q = freg;

  p_zero_matches_result_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op <= OP_SRL) |=> (freg.z == (res_q == '0)));

  p_sign_matches_result_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op <= OP_SRL) |=> (freg.s == res_q[DW-1]));

  p_user_flags_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> (flags_q[1:0] == $past(flags_in[1:0])));

  p_logic_keeps_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op >= OP_AND && op <= OP_XOR) |=>
      (freg.c == $past(fin.c) && freg.d == $past(fin.d) &&
       freg.h == $past(fin.h) && !freg.v));

  p_hold_when_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> ($stable(res_q) && $stable(flags_q)));

  p_direction_flag_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (en && op <= OP_SBC) |=> (freg.d == $past(op[1])));
endmodule

// File: tb/alu_flag_unit_bench.sv
`timescale 1ns/1ps
module alu_flag_unit_bench;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       en;
  logic [3:0] op;
  logic [7:0] opnd_a, opnd_b, flags_in;
  logic [3:0] cc;
  logic [7:0] res_q, flags_q;
  logic       cond_true;
  int         checks = 0;
  int         errors = 0;
  bit         done   = 0;

  always #2.5 clk = ~clk;

  alu_flag_unit u_alu_flag_unit (
    .clk(clk), .rst_n(rst_n), .en(en), .op(op), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .flags_in(flags_in), .cc(cc), .res_q(res_q),
    .flags_q(flags_q), .cond_true(cond_true)
  );

  function automatic logic [15:0] model(input logic [3:0] o, input logic [7:0] a,
                                        input logic [7:0] b, input logic [7:0] f);
    logic [7:0] r, nf;
    int t, ai, bi, ci;
    nf = f; r = a; ai = int'(a); bi = int'(b);
    ci = int'(f[7]);
    case (o)
      4'd0, 4'd1: begin
        if (o == 4'd0) ci = 0;
        t = ai + bi + ci; r = t[7:0];
        nf[7] = (t > 255);
        nf[2] = ((ai % 16) + (bi % 16) + ci) > 15;
        nf[4] = (a[7] == b[7]) && (r[7] != a[7]);
        nf[3] = 1'b0;
      end
      4'd2, 4'd3: begin
        if (o == 4'd2) ci = 0;
        t = ai - bi - ci; r = t[7:0];
        nf[7] = (t < 0);
        nf[2] = ((ai % 16) - (bi % 16) - ci) < 0;
        nf[4] = (a[7] != b[7]) && (r[7] == b[7]);
        nf[3] = 1'b1;
      end
      4'd4: begin r = a & b; nf[4] = 1'b0; end
      4'd5: begin r = a | b; nf[4] = 1'b0; end
      4'd6: begin r = a ^ b; nf[4] = 1'b0; end
      4'd7:  begin r = {a[6:0], a[7]}; nf[7] = a[7]; end
      4'd8:  begin r = {a[6:0], f[7]}; nf[7] = a[7]; end
      4'd9:  begin r = {a[0], a[7:1]}; nf[7] = a[0]; end
      4'd10: begin r = {f[7], a[7:1]}; nf[7] = a[0]; end
      4'd11: begin r = {a[7], a[7:1]}; nf[7] = a[0]; end
      4'd12: begin r = {1'b0, a[7:1]}; nf[7] = a[0]; end
      default: return {f, a};
    endcase
    if (o >= 4'd7) nf[4] = r[7] ^ a[7];
    nf[6] = (r == 8'h00);
    nf[5] = r[7];
    return {nf, r};
  endfunction

  function automatic logic cond_model(input logic [3:0] c, input logic [7:0] f);
    logic fc, fz, fs, fv;
    fc = f[7]; fz = f[6]; fs = f[5]; fv = f[4];
    case (c)
      4'h0: return 1'b0;
      4'h1: return fs ^ fv;
      4'h2: return fz | (fs ^ fv);
      4'h3: return fc | fz;
      4'h4: return fv;
      4'h5: return fs;
      4'h6: return fz;
      4'h7: return fc;
      4'h8: return 1'b1;
      4'h9: return !(fs ^ fv);
      4'hA: return !(fz | (fs ^ fv));
      4'hB: return !(fc | fz);
      4'hC: return !fv;
      4'hD: return !fs;
      4'hE: return !fz;
      default: return !fc;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] o);
    if (o <= 4'd1) return "R1";
    if (o <= 4'd3) return "R2";
    if (o <= 4'd6) return "R6";
    if (o <= 4'd12) return "R7";
    return "R9";
  endfunction

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s got=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic run_op(input logic [3:0] o, input logic [7:0] a,
                        input logic [7:0] b, input logic [7:0] f);
    logic [15:0] exp;
    @(negedge clk);
    op = o; opnd_a = a; opnd_b = b; flags_in = f; en = 1'b1;
    exp = model(o, a, b, f);
    @(negedge clk);
    en = 1'b0;
    check(tag_of(o), {flags_q, res_q}, exp);
    if (o <= 4'd12) begin
      check("R3", {15'd0, flags_q[6]}, {15'd0, res_q == 8'h00});
      check("R4", {15'd0, flags_q[5]}, {15'd0, res_q[7]});
    end
    check("R8", {14'd0, flags_q[1:0]}, {14'd0, f[1:0]});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; en = 1'b0; op = '0; opnd_a = '0; opnd_b = '0;
    flags_in = '0; cc = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R10 reset", {flags_q, res_q}, 16'h0000);

    // R1 / R5 corners
    run_op(4'd0, 8'h7F, 8'h01, 8'h00);  // V, H, S
    run_op(4'd0, 8'hFF, 8'h01, 8'h03);  // C, Z, H, user flags kept
    run_op(4'd1, 8'h0F, 8'h00, 8'h80);  // carry in gives H
    run_op(4'd0, 8'h80, 8'h80, 8'h08);  // V from negatives, D cleared
    // R2 / R5 corners
    run_op(4'd2, 8'h80, 8'h01, 8'h00);  // V on subtract
    run_op(4'd2, 8'h00, 8'h01, 8'h00);  // borrow, H
    run_op(4'd3, 8'h10, 8'h0F, 8'h80);  // borrow in, zero result
    run_op(4'd2, 8'h01, 8'h80, 8'h00);  // V with positive minus negative
    // R6
    run_op(4'd4, 8'hF0, 8'h0F, 8'hFF);
    run_op(4'd5, 8'h80, 8'h01, 8'h9C);
    run_op(4'd6, 8'hAA, 8'hAA, 8'h14);
    // R7
    run_op(4'd7,  8'h80, 8'h00, 8'h00);
    run_op(4'd8,  8'h40, 8'h00, 8'h80);
    run_op(4'd9,  8'h01, 8'h00, 8'h0C);
    run_op(4'd10, 8'h01, 8'h00, 8'h00);
    run_op(4'd11, 8'h81, 8'h00, 8'h00);
    run_op(4'd12, 8'h80, 8'h00, 8'h0C);
    // R9
    run_op(4'd13, 8'h5A, 8'h11, 8'hA5);
    run_op(4'd15, 8'h00, 8'hFF, 8'h3C);

    // R10 hold: change inputs with en low
    begin
      logic [15:0] held;
      held = {flags_q, res_q};
      @(negedge clk);
      op = 4'd0; opnd_a = 8'h12; opnd_b = 8'h34; flags_in = 8'hFF;
      repeat (3) @(negedge clk);
      check("R10 hold", {flags_q, res_q}, held);
    end

    // Random ops with flag feedback
    for (int i = 0; i < 400; i++) begin
      logic [7:0] f;
      f = (i % 3 == 0) ? 8'($urandom) : flags_q;
      run_op(4'($urandom), 8'($urandom), 8'($urandom), f);
    end

    // R11: every condition code over many flag patterns
    for (int k = 0; k < 64; k++) begin
      for (int c = 0; c < 16; c++) begin
        @(negedge clk);
        flags_in = {k[3:0], 4'($urandom)};
        cc = 4'(c);
        #1;
        check("R11", {15'd0, cond_true}, {15'd0, cond_model(4'(c), flags_in)});
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule